// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where an RV64 core fetches next and what return address a jump leaves behind. Each cycle it takes one 32-bit instruction word, the address that word was fetched from, and the two source operand values already read from the register file. It produces the following fetch address, a flag that says whether a return address must be written, and that return address.

Conditional branches compare the two operands, either signed or unsigned. A taken branch moves by the sign-extended B-format offset and a branch that is not taken steps by four bytes. The direct jump adds the sign-extended J-format offset to the PC. The register jump adds a sign-extended 12-bit immediate to the first operand and then clears bit 0 of the sum. Both jumps record PC+4 unless their destination register is x0. Any other instruction simply steps to PC+4.

The outputs are registered. The result for an instruction presented in one cycle appears after the next rising clock edge. A parameter chooses between one shared address adder and four parallel adders.

Top module: `nxpc_unit`

## Requirements
- R1: While the synchronous active-high reset is applied at a rising edge, the registers load zero: next_pc = 0, link_we = 0 and link_val = 0.
- R2: The outputs after a rising edge reflect the inputs sampled at that edge. Instructions given in consecutive cycles each produce their own result one cycle later.
- R3: The branch opcode is 1100011 in inst[6:0]. funct3 is held in inst[14:12]. funct3 000 branches when the operands are equal, and funct3 001 branches when they differ.
- R4: funct3 100 branches when op_a < op_b as signed values, and funct3 101 branches when op_a >= op_b as signed values.
- R5: funct3 110 and 111 make the same two tests on unsigned values. With op_a = 0xF000000000000000 and op_b = 42, the 100 and 111 branches are taken and the 101 and 110 branches are not.
- R6: A taken branch gives next_pc = pc + offset. The offset is the sign-extended 13-bit value {inst[31], inst[7], inst[30:25], inst[11:8], 0}, and both negative and extreme offsets are allowed. A branch that is not taken gives pc + 4. A branch never writes a link.
- R7: The direct jump uses opcode 1101111. It gives next_pc = pc + the sign-extended {inst[31], inst[19:12], inst[20], inst[30:21], 0} and link_val = pc + 4. The word 0xFFDFF0EF means a jump of -4.
- R8: The register jump uses opcode 1100111 with funct3 000. It gives next_pc = (op_a + sign-extended inst[31:20]) with bit 0 forced to 0, and link_val = pc + 4.
- R9: link_we is 1 only for the two jumps, and only when rd = inst[11:7] is not zero. A jump to rd = x0 still redirects.
- R10: Any other opcode, a branch with reserved funct3 010 or 011, and opcode 1100111 with funct3 not equal to 000 all give next_pc = pc + 4 and link_we = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| op_a | input | XLEN | First source operand (rs1 value) |
| op_b | input | XLEN | Second source operand (rs2 value) |
| next_pc | output | XLEN | Registered next fetch address |
| link_we | output | 1 | Registered return-address write enable |
| link_val | output | XLEN | Registered return address (PC+4) |

## Verification
A jump both redirects the PC and writes a return address in the same output cycle. These are two separate functions that must agree on the same PC. The bench sends jumps with a non-zero rd and forward, backward and odd-sum targets. For each one it checks the redirect address and the link value against a single expected entry popped from its scoreboard. Jumps to rd = x0 then split the two functions apart: the redirect must still happen while the link write is suppressed.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  // Control-flow class of the current instruction
  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_JMP  = 2'd2,
    FLOW_JREG = 2'd3
  } flow_e;

  // Comparison selected by funct3[2:1]
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_RSV = 2'b01,
    CMP_LTS = 2'b10,
    CMP_LTU = 2'b11
  } cmp_e;

endpackage

// File: rtl/nxpc_imm_decode.sv
module nxpc_imm_decode #(
  parameter int XLEN = 64
) (
  input  logic [31:7]     ifield,
  output logic [XLEN-1:0] b_off,
  output logic [XLEN-1:0] j_off,
  output logic [XLEN-1:0] i_off
);
  localparam int BW = 13;
  localparam int JW = 21;
  localparam int IW = 12;

  logic [BW-1:0] b_raw;
  logic [JW-1:0] j_raw;
  logic [IW-1:0] i_raw;

  always_comb begin
    b_raw = {ifield[31], ifield[7], ifield[30:25], ifield[11:8], 1'b0};
    j_raw = {ifield[31], ifield[19:12], ifield[20], ifield[30:21], 1'b0};
    i_raw = ifield[31:20];
    b_off = {{(XLEN-BW){b_raw[BW-1]}}, b_raw};
    j_off = {{(XLEN-JW){j_raw[JW-1]}}, j_raw};
    i_off = {{(XLEN-IW){i_raw[IW-1]}}, i_raw};
  end
endmodule

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval
  import nxpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      f3,
  output logic            take
);
  logic  eq, lt_s, lt_u, base;
  cmp_e  sel;

  always_comb begin
    eq   = (a == b);
    lt_s = ($signed(a) < $signed(b));
    lt_u = (a < b);
    sel  = cmp_e'(f3[2:1]);
    base = 1'b0;
    case (sel)
      CMP_EQ:  base = eq;
      CMP_LTS: base = lt_s;
      CMP_LTU: base = lt_u;
      default: base = 1'b0;
    endcase
    // funct3[0] inverts the test; reserved codes never branch
    take = (sel == CMP_RSV) ? 1'b0 : (base ^ f3[0]);
  end
endmodule

// File: rtl/nxpc_target_sel.sv
module nxpc_target_sel
  import nxpc_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  flow_e           flow,
  input  logic            take,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base_reg,
  input  logic [XLEN-1:0] b_off,
  input  logic [XLEN-1:0] j_off,
  input  logic [XLEN-1:0] i_off,
  output logic [XLEN-1:0] npc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  generate
    if (SHARED_ADDER) begin : g_shared
      logic [XLEN-1:0] base, off, sum;
      always_comb begin
        base = (flow == FLOW_JREG) ? base_reg : pc;
        case (flow)
          FLOW_BR:   off = take ? b_off : STEP;
          FLOW_JMP:  off = j_off;
          FLOW_JREG: off = i_off;
          default:   off = STEP;
        endcase
        sum = base + off;
        npc = (flow == FLOW_JREG) ? {sum[XLEN-1:1], 1'b0} : sum;
      end
    end else begin : g_parallel
      logic [XLEN-1:0] seq_t, br_t, jmp_t, jr_sum;
      always_comb begin
        seq_t  = pc + STEP;
        br_t   = pc + b_off;
        jmp_t  = pc + j_off;
        jr_sum = base_reg + i_off;
        case (flow)
          FLOW_BR:   npc = take ? br_t : seq_t;
          FLOW_JMP:  npc = jmp_t;
          FLOW_JREG: npc = {jr_sum[XLEN-1:1], 1'b0};
          default:   npc = seq_t;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     inst,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_val
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [6:0]      opcode;
  logic [2:0]      f3;
  logic [4:0]      rd;
  flow_e           flow;
  logic            take;
  logic            link_d;
  logic [XLEN-1:0] b_off, j_off, i_off, npc_d;

  assign opcode = inst[6:0];
  assign f3     = inst[14:12];
  assign rd     = inst[11:7];

  always_comb begin
    case (opcode)
      OPC_BRANCH: flow = FLOW_BR;
      OPC_JAL:    flow = FLOW_JMP;
      OPC_JALR:   flow = (f3 == 3'b000) ? FLOW_JREG : FLOW_SEQ;
      default:    flow = FLOW_SEQ;
    endcase
    link_d = ((flow == FLOW_JMP) || (flow == FLOW_JREG)) && (rd != 5'd0);
  end

  nxpc_imm_decode #(.XLEN(XLEN)) u_imm (
    .ifield (inst[31:7]),
    .b_off  (b_off),
    .j_off  (j_off),
    .i_off  (i_off)
  );

  nxpc_cond_eval #(.XLEN(XLEN)) u_cond (
    .a    (op_a),
    .b    (op_b),
    .f3   (f3),
    .take (take)
  );

  nxpc_target_sel #(.XLEN(XLEN), .SHARED_ADDER(SHARED_ADDER)) u_tgt (
    .flow     (flow),
    .take     (take),
    .pc       (pc),
    .base_reg (op_a),
    .b_off    (b_off),
    .j_off    (j_off),
    .i_off    (i_off),
    .npc      (npc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc  <= '0;
      link_we  <= 1'b0;
      link_val <= '0;
    end else begin
      next_pc  <= npc_d;
      link_we  <= link_d;
      link_val <= pc + STEP;
    end
  end

  // R1: first cycle out of reset shows the cleared registers
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (next_pc == '0 && !link_we && link_val == '0));

  // R7/R8: a written link is always the return address of the prior instruction
  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && link_we) |-> (link_val == $past(pc) + STEP));

  // R8: register-jump targets are even
  a_r8_jalr_even: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OPC_JALR && $past(f3) == 3'b000)
      |-> (next_pc[0] == 1'b0));

  // R9: rd of x0 never writes a link
  a_r9_x0_no_link: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd) == 5'd0) |-> !link_we);

  // R6: a branch lands on one of its two possible targets and never links
  a_r6_branch_two_way: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OPC_BRANCH)
      |-> (!link_we && (next_pc == $past(pc) + STEP ||
                        next_pc == $past(pc) + $past(b_off))));

  // R10: non-control instructions fall through
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) != OPC_BRANCH && $past(opcode) != OPC_JAL &&
     $past(opcode) != OPC_JALR) |-> (next_pc == $past(pc) + STEP && !link_we));

endmodule

// File: tb/nxpc_unit_test.sv
`timescale 1ns/1ps
module nxpc_unit_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     inst = 32'h0000_0013;
  logic [XLEN-1:0] pc = '0;
  logic [XLEN-1:0] op_a = '0;
  logic [XLEN-1:0] op_b = '0;
  logic [XLEN-1:0] next_pc, link_val;
  logic            link_we;

  int total = 0;
  int bad = 0;

  logic [63:0] q_npc[$];
  bit          q_we[$];
  logic [63:0] q_lv[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  nxpc_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .inst(inst), .pc(pc), .op_a(op_a), .op_b(op_b),
    .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  localparam logic [63:0] P = 64'h0000_0000_8000_1000;

  function automatic logic [63:0] addo(logic [63:0] a, int o);
    return a + {{32{o[31]}}, o};
  endfunction

  function automatic logic [31:0] enc_b(logic [2:0] f3, int off);
    logic [12:0] o;
    o = off[12:0];
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(int off, logic [4:0] rd);
    logic [20:0] o;
    o = off[20:0];
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_i(int imm, logic [2:0] f3, logic [4:0] rd);
    return {imm[11:0], 5'd2, f3, rd, 7'b1100111};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present one instruction and queue what must appear
  task automatic drive(logic [31:0] w, logic [63:0] p, logic [63:0] a,
                       logic [63:0] b, logic [63:0] exp_npc, bit exp_we,
                       string tag);
    @(negedge clk);
    inst = w; pc = p; op_a = a; op_b = b;
    q_npc.push_back(exp_npc);
    q_we.push_back(exp_we);
    q_lv.push_back(p + 64'd4);
    q_tag.push_back(tag);
  endtask

  // Monitor: one result per rising edge, sampled 1 ns later
  initial begin
    int n;
    logic [63:0] e_npc, e_lv;
    bit e_we;
    string t;
    forever begin
      @(posedge clk);
      n = q_npc.size();
      #1;
      if (n > 0 && !rst) begin
        e_npc = q_npc.pop_front();
        e_we  = q_we.pop_front();
        e_lv  = q_lv.pop_front();
        t     = q_tag.pop_front();
        check(next_pc == e_npc, {t, " next_pc"}, next_pc, e_npc);
        check(link_we == e_we, {t, " link_we"}, {63'd0, link_we}, {63'd0, e_we});
        if (e_we) check(link_val == e_lv, {t, " link_val"}, link_val, e_lv);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    inst = enc_j(8, 5'd1); pc = P;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(next_pc == '0, "R1 next_pc", next_pc, 64'd0);
    check(link_we == 1'b0, "R1 link_we", {63'd0, link_we}, 64'd0);
    check(link_val == '0, "R1 link_val", link_val, 64'd0);
    rst = 1'b0;

    // R3 equal / not equal
    drive(enc_b(3'b000, 8), P, 64'd42, 64'd42, P + 8, 0, "R3 beq taken");
    drive(enc_b(3'b000, 8), P, 64'd41, 64'd42, P + 4, 0, "R3 beq not");
    drive(enc_b(3'b001, 8), P, 64'd42, 64'd42, P + 4, 0, "R3 bne not");
    drive(enc_b(3'b001, 8), P, 64'd42, 64'd41, P + 8, 0, "R3 bne taken");
    // R4 signed
    drive(enc_b(3'b100, 8), P, 64'd41, 64'd42, P + 8, 0, "R4 blt taken");
    drive(enc_b(3'b101, 8), P, 64'd42, 64'd42, P + 8, 0, "R4 bge equal");
    drive(enc_b(3'b100, 8), P, 64'hF000_0000_0000_0000, 64'd42, P + 8, 0, "R4 blt neg");
    drive(enc_b(3'b101, 8), P, 64'hF000_0000_0000_0000, 64'd42, P + 4, 0, "R4 bge neg");
    // R5 unsigned
    drive(enc_b(3'b110, 8), P, 64'hF000_0000_0000_0000, 64'd42, P + 4, 0, "R5 bltu big");
    drive(enc_b(3'b111, 8), P, 64'hF000_0000_0000_0000, 64'd42, P + 8, 0, "R5 bgeu big");
    drive(enc_b(3'b110, 8), P, 64'd41, 64'd42, P + 8, 0, "R5 bltu small");
    drive(enc_b(3'b111, 8), P, 64'd41, 64'd42, P + 4, 0, "R5 bgeu small");
    // R6 offsets
    drive(enc_b(3'b000, -4), P, 64'd7, 64'd7, addo(P, -4), 0, "R6 back 4");
    drive(enc_b(3'b000, -4096), P, 64'd7, 64'd7, addo(P, -4096), 0, "R6 min off");
    drive(enc_b(3'b000, 4094), P, 64'd7, 64'd7, addo(P, 4094), 0, "R6 max off");
    // R7 direct jump with link
    drive(enc_j(8, 5'd1), P, 64'd0, 64'd0, P + 8, 1, "R7 jal fwd");
    drive(32'hFFDF_F0EF, P + 64'h40, 64'd0, 64'd0, P + 64'h3C, 1, "R7 jal -4");
    drive(enc_j(-1048576, 5'd5), 64'h0000_0000_4010_0000, 64'd0, 64'd0,
          64'h0000_0000_4000_0000, 1, "R7 jal min");
    // R8 register jump
    drive(enc_i(4, 3'b000, 5'd1), P, P + 38, 64'd0, P + 42, 1, "R8 jalr +4");
    drive(enc_i(-4, 3'b000, 5'd1), P, P + 42, 64'd0, P + 38, 1, "R8 jalr -4");
    drive(enc_i(5, 3'b000, 5'd1), P, P + 38, 64'd0, P + 42, 1, "R8 jalr odd");
    // R9 rd = x0
    drive(enc_j(16, 5'd0), P, 64'd0, 64'd0, P + 16, 0, "R9 jal x0");
    drive(enc_i(0, 3'b000, 5'd0), P, 64'h1235, 64'd0, 64'h1234, 0, "R9 jalr x0");
    // R10 fall-through cases
    drive(32'h0031_00B3, P, 64'd1, 64'd2, P + 4, 0, "R10 add");
    drive(enc_b(3'b010, 8), P, 64'd3, 64'd3, P + 4, 0, "R10 rsv 010");
    drive(enc_b(3'b011, 8), P, 64'd3, 64'd4, P + 4, 0, "R10 rsv 011");
    drive(enc_i(8, 3'b001, 5'd1), P, P, 64'd0, P + 4, 0, "R10 jalr f3");
    // R2 back-to-back distinct PCs
    drive(32'h0000_0013, 64'h100, 64'd0, 64'd0, 64'h104, 0, "R2 seq a");
    drive(enc_j(32, 5'd3), 64'h200, 64'd0, 64'd0, 64'h220, 1, "R2 seq b");
    drive(32'h0000_0013, 64'h300, 64'd0, 64'd0, 64'h304, 0, "R2 seq c");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule